// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block sits between a fast peripheral register bus and a bank of registers that live in a slower, separately clocked domain. A write aimed at a slow register is captured in a holding register. A toggle request carries it across the clock boundary, the slow side commits it with a one-cycle write strobe, and a toggle acknowledge travels back. While a write is in flight, a write-complete status bit reads low. When the acknowledge returns, the bit reads high again, a shadow copy on the bus side is updated, and a sticky interrupt status bit is set. The interrupt output is that status bit gated by a mask bit.

Reads never cross the boundary. They are served from the shadow copy and the local control registers in the same bus cycle, so reads can follow each other on every cycle. Software must wait for write-complete before it issues another slow write or a slow read. The bridge drops such an access and records a sticky violation flag.

The bus-side state machine has two states. `BUS_IDLE` moves to `BUS_BUSY` on an accepted slow write ("accept"), and `BUS_BUSY` returns to `BUS_IDLE` when the synchronized acknowledge matches the request ("done"). The slow-side state machine also has two states. `SLW_WAIT` moves to `SLW_COMMIT` when the synchronized request differs from the local acknowledge ("new request"), and `SLW_COMMIT` always returns to `SLW_WAIT` after one slow cycle, flipping the acknowledge ("commit").

Top module: `slow_reg_bridge`

## Requirements
- R1: After reset, the write-complete bit (bit 0 of the status register at address 8) reads 1, the violation bit (bit 1 of that register) reads 0, and `irq` is 0.
- R2: A write to a slow address (address below NREG) while write-complete is 1 makes write-complete read 0 from the next bus cycle onward.
- R3: Each accepted slow write appears on the slow port exactly once, as a one-slow-cycle `slow_we` pulse carrying the captured address and data.
- R4: Write-complete returns to 1 once the acknowledge has come back. From then on, a read of that slow address returns the written data.
- R5: A slow write or slow read issued while write-complete is 0 sets the sticky violation bit and has no effect on the registers. A dropped write causes no slow strobe and leaves the shadow unchanged. Writing 1 to status bit 1 clears the violation bit.
- R6: Reads of slow addresses (while idle) and of the local registers return data combinationally in the same cycle. Consecutive cycles of reads have no spacing limit.
- R7: Bit 0 of the interrupt status register at address 9 is set by every completed write and stays set until software writes 1 to it. If a completion and a clear arrive in the same cycle, the set wins.
- R8: `irq` is high exactly when the interrupt status bit and the mask bit (bit 0 of address 10, reset 0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register-bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| slow_clk | input | 1 | Slow-domain clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, valid in the cycle of the read |
| irq | output | 1 | Masked write-complete interrupt |
| slow_we | output | 1 | Slow-domain write strobe |
| slow_waddr | output | log2(NREG) | Slow-domain write address |
| slow_wdata | output | DW | Slow-domain write data |

## Verification
The bench goes after the cycle right after an accepted write. A bridge that derived write-complete from the returning acknowledge alone would still read 1 there. It issues a second write and a read one cycle after a write. A design that let the second write through would emit two slow strobes and leave the wrong value in the shadow, and one that ignored the read would never raise the violation flag. It checks that the interrupt stays low while the mask is 0 and rises when the mask is set, which a design that skips the masking would get wrong. It also checks that a write-one clear removes the interrupt. Randomized writes through the full handshake compare the shadow, the slow-port writes and the strobe count against a bench model.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    typedef enum logic {
        SLW_WAIT   = 1'b0,
        SLW_COMMIT = 1'b1
    } slow_state_e;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bridge_bus_side.sv
module bridge_bus_side
    import bridge_pkg::*;
#(
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wr,
    input  logic                     rd,
    output logic [DW-1:0]            rdata,
    output logic                     irq,
    output logic                     req_tgl,
    input  logic                     ack_sync,
    output logic [$clog2(NREG)-1:0]  hold_addr,
    output logic [DW-1:0]            hold_data
);
    localparam int IW = $clog2(NREG);
    localparam logic [AW-1:0] LOC_STATUS = AW'(1 << (AW-1));
    localparam logic [AW-1:0] LOC_IRQ    = LOC_STATUS + AW'(1);
    localparam logic [AW-1:0] LOC_MASK   = LOC_STATUS + AW'(2);

    bus_state_e state_q, state_d;
    logic [DW-1:0] shadow_q [NREG];
    logic          viol_q, irq_raw_q, mask_q;

    logic is_slow, busy, wc, accept, done, viol_evt;

    assign is_slow  = int'(addr) < NREG;
    assign busy     = (state_q == BUS_BUSY);
    assign wc       = !busy;
    assign accept   = wr && is_slow && !busy;
    assign done     = busy && (ack_sync == req_tgl);
    assign viol_evt = busy && is_slow && (wr || rd);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (accept) state_d = BUS_BUSY;
            BUS_BUSY: if (done)   state_d = BUS_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            viol_q    <= 1'b0;
            irq_raw_q <= 1'b0;
            mask_q    <= 1'b0;
            for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
        end else begin
            if (accept) begin
                hold_addr <= addr[IW-1:0];
                hold_data <= wdata;
                req_tgl   <= !req_tgl;
            end
            if (done) shadow_q[hold_addr] <= hold_data;

            if (viol_evt)
                viol_q <= 1'b1;
            else if (wr && addr == LOC_STATUS && wdata[1])
                viol_q <= 1'b0;

            if (done)
                irq_raw_q <= 1'b1;
            else if (wr && addr == LOC_IRQ && wdata[0])
                irq_raw_q <= 1'b0;

            if (wr && addr == LOC_MASK) mask_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (is_slow)                rdata = shadow_q[addr[IW-1:0]];
        else if (addr == LOC_STATUS) rdata = DW'({viol_q, wc});
        else if (addr == LOC_IRQ)    rdata = DW'(irq_raw_q);
        else if (addr == LOC_MASK)   rdata = DW'(mask_q);
    end

    assign irq = irq_raw_q && mask_q;

    AST_WC_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !wc); // R2
    AST_WC_BACK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> wc); // R4
    AST_VIOL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        viol_evt |=> viol_q); // R5
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_data) && $stable(hold_addr)); // R5
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_raw_q); // R7
endmodule

// File: rtl/bridge_slow_side.sv
module bridge_slow_side
    import bridge_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_sync,
    input  logic [$clog2(NREG)-1:0]  hold_addr,
    input  logic [DW-1:0]            hold_data,
    output logic                     ack_tgl,
    output logic                     we,
    output logic [$clog2(NREG)-1:0]  waddr,
    output logic [DW-1:0]            wdata
);
    slow_state_e state_q, state_d;
    logic new_req;

    assign new_req = (req_sync != ack_tgl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLW_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLW_WAIT:   if (new_req) state_d = SLW_COMMIT;
            SLW_COMMIT: state_d = SLW_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_tgl <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
        end else begin
            if (state_q == SLW_WAIT && new_req) begin
                waddr <= hold_addr;
                wdata <= hold_data;
            end
            if (state_q == SLW_COMMIT) ack_tgl <= !ack_tgl;
        end
    end

    assign we = (state_q == SLW_COMMIT);

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we); // R3
    AST_ACK_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_tgl != $past(ack_tgl)) |-> $past(we)); // R3
endmodule

// File: rtl/slow_reg_bridge.sv
module slow_reg_bridge #(
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input  logic                     bus_clk,
    input  logic                     bus_rst_n,
    input  logic                     slow_clk,
    input  logic                     slow_rst_n,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [DW-1:0]            bus_rdata,
    output logic                     irq,
    output logic                     slow_we,
    output logic [$clog2(NREG)-1:0]  slow_waddr,
    output logic [DW-1:0]            slow_wdata
);
    localparam int IW      = $clog2(NREG);
    localparam int SYNC_FF = 2;

    logic          req_tgl, req_s, ack_tgl, ack_s;
    logic [IW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    bridge_bus_side #(.AW(AW), .DW(DW), .NREG(NREG)) u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr), .rd(bus_rd),
        .rdata(bus_rdata), .irq(irq),
        .req_tgl(req_tgl), .ack_sync(ack_s),
        .hold_addr(hold_addr), .hold_data(hold_data)
    );

    bridge_sync #(.STAGES(SYNC_FF)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s)
    );

    bridge_sync #(.STAGES(SYNC_FF)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s)
    );

    bridge_slow_side #(.DW(DW), .NREG(NREG)) u_slow (
        .clk(slow_clk), .rst_n(slow_rst_n),
        .req_sync(req_s), .hold_addr(hold_addr), .hold_data(hold_data),
        .ack_tgl(ack_tgl), .we(slow_we), .waddr(slow_waddr), .wdata(slow_wdata)
    );
endmodule

// File: tb/tb_slow_reg_bridge.sv
module tb_slow_reg_bridge;
    localparam int AW = 4, DW = 16, NREG = 4;
    localparam logic [AW-1:0] A_STATUS = 4'd8, A_IRQ = 4'd9, A_MASK = 4'd10;

    logic bus_clk = 0, slow_clk = 0, bus_rst_n = 0, slow_rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [DW-1:0] bus_rdata;
    logic irq, slow_we;
    logic [1:0] slow_waddr;
    logic [DW-1:0] slow_wdata;

    always #5  bus_clk  = ~bus_clk;
    always #23 slow_clk = ~slow_clk;

    slow_reg_bridge #(.AW(AW), .DW(DW), .NREG(NREG)) dut (.*);

    int checks = 0, fails = 0, strobes = 0;
    bit finished = 0;
    logic [DW-1:0] exp_reg [NREG];
    logic [DW-1:0] slow_model [NREG];

    always @(posedge slow_clk) if (slow_we) begin
        slow_model[slow_waddr] <= slow_wdata;
        strobes <= strobes + 1;
    end

    function automatic logic [DW-1:0] exp_status(input bit wc, input bit viol);
        return DW'({viol, wc});
    endfunction
    function automatic bit exp_irq(input bit raw, input bit mask);
        return raw & mask;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge bus_clk);
        bus_rd = 0;
    endtask

    task automatic wait_wc(input string req);
        logic [DW-1:0] s;
        int n = 0;
        do begin
            bus_read(A_STATUS, s);
            n++;
        end while (s[0] !== 1'b1 && n < 300);
        check(req, DW'(s[0]), DW'(1));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] r;
        int s0;
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) begin exp_reg[i] = '0; slow_model[i] = '0; end
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1; slow_rst_n = 1;
        @(negedge bus_clk);

        // R1 reset state
        bus_read(A_STATUS, r); check("R1 status", r, exp_status(1, 0));
        check("R1 irq", DW'(irq), DW'(0));
        bus_read(4'd2, r); check("R1 shadow", r, '0);

        // random writes with full handshake; R2 R3 R4 R7 R8 (mask 0)
        for (int it = 0; it < 40; it++) begin
            logic [1:0] a = 2'($urandom_range(0, NREG - 1));
            logic [DW-1:0] d = DW'($urandom);
            s0 = strobes;
            bus_write(AW'(a), d);
            exp_reg[a] = d;
            bus_read(A_STATUS, r); check("R2 wc low", r, exp_status(0, 0));
            wait_wc("R4 wc back");
            repeat (4) @(negedge bus_clk);
            bus_read(AW'(a), r); check("R4 shadow", r, exp_reg[a]);
            check("R3 slow data", slow_model[a], d);
            check("R3 one strobe", DW'(strobes - s0), DW'(1));
            check("R8 irq masked", DW'(irq), DW'(exp_irq(1, 0)));
        end

        // R6 back-to-back reads, one per cycle
        for (int i = 0; i < NREG; i++) begin
            bus_read(AW'(i), r); check("R6 b2b read", r, exp_reg[i]);
        end
        bus_read(A_IRQ, r); check("R7 raw sticky", r, DW'(1));

        // R8 unmask, then R7 clear
        bus_write(A_MASK, DW'(1));
        check("R8 irq on", DW'(irq), DW'(exp_irq(1, 1)));
        bus_write(A_IRQ, DW'(1));
        check("R7 irq cleared", DW'(irq), DW'(exp_irq(0, 1)));
        bus_read(A_IRQ, r); check("R7 raw cleared", r, DW'(0));

        // R5 second write while busy is dropped
        s0 = strobes;
        bus_write(4'd1, 16'hA5A5);
        bus_write(4'd1, 16'h5A5A);
        exp_reg[1] = 16'hA5A5;
        wait_wc("R5 wc back");
        repeat (4) @(negedge bus_clk);
        bus_read(4'd1, r); check("R5 dropped write", r, exp_reg[1]);
        check("R5 strobe count", DW'(strobes - s0), DW'(1));
        bus_read(A_STATUS, r); check("R5 viol set", r, exp_status(1, 1));
        check("R7 irq after done", DW'(irq), DW'(exp_irq(1, 1)));
        bus_write(A_STATUS, DW'(2));
        bus_read(A_STATUS, r); check("R5 viol cleared", r, exp_status(1, 0));

        // R5 read right after a write
        bus_write(4'd3, 16'h1234);
        exp_reg[3] = 16'h1234;
        bus_read(4'd3, r);
        bus_read(A_STATUS, r); check("R5 read viol", r, exp_status(0, 1));
        wait_wc("R5 wc after read viol");
        bus_read(4'd3, r); check("R4 shadow after viol", r, exp_reg[3]);

        finish_run();
    end
endmodule